// File: doc/BRIEF.md
# Two-Cell Shunt Balancing Controller

This block governs the bypass shunts of a pack made of two cells in series. It counts one-second ticks. When a programmable number of them has passed while it is idle, it runs a balancing pass. A pass first asks the charge path to pause and opens both shunts. It then lets the cells settle for a programmable number of clock cycles, so that no impedance drop from the charge current remains in the readings. After that it fetches the voltage of cell 1 and then cell 2 through a request/valid handshake.

From the two readings it forms the higher and the lower voltage and their difference. It then applies the rule for the present phase. In charge, the difference must exceed a charge threshold, and balancing is vetoed in constant-voltage mode when the current has dropped below a floor. In discharge, the difference must exceed a separate threshold and the higher cell must sit at or above a mid-charge voltage. At most one active-high shunt enable is driven. The pause is lifted in the same cycle, and a programmable end delay runs before the next pass may start.

The chosen shunt stays closed until the next pass or a synchronous clear, which the surrounding charger raises in its complete, error and temperature-wait states. If a reading does not arrive in time, the pass is abandoned and a one-cycle fault pulse is issued.

Top module: `cell_shunt_balancer`

## Requirements
- R1: A pass starts on the secTick that completes intervalSecs ticks counted while idle (a value of 0 acts as 1); chargeSuspend rises in the cycle after that tick. Ticks arriving during a pass, including its end delay, are ignored.
- R2: In the cycle chargeSuspend rises, both shunt enables are low, and they stay low until the decision of that pass.
- R3: cellReq is first raised startDelay+1 cycles after chargeSuspend rises, and cellReq is only ever high while chargeSuspend is high.
- R4: Cell 1 is requested first (cellSel=0), then cell 2 (cellSel=1); each request is held until cellValid is seen high at a clock edge, and cellVolt is captured at that edge.
- R5: In the charge phase (dischargePhase=0), a shunt is closed only if (max−min) > chgMinDiff and not (cvMode=1 and chargeCurrent < minBalCurrent).
- R6: In the discharge phase (dischargePhase=1), a shunt is closed only if (max−min) > dchgMinDiff and max ≥ midVolt.
- R7: When balancing is called for, shunt1En is driven high if cell 1 reads strictly higher than cell 2, otherwise shunt2En; the two enables are never high together.
- R8: The shunt decision appears in the same cycle that chargeSuspend falls; the selected enable then holds until the next pass opens it.
- R9: While shuntClear is high, both enables are low from the next cycle on, and the clear overrides a decision taken in the same cycle.
- R10: If cellValid does not arrive within measTimeout+1 cycles of a request, the request drops, chargeSuspend falls, both enables stay low and measFault is high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| shuntClear | input | 1 | Synchronous force-open of both shunts |
| secTick | input | 1 | One-cycle pulse each second |
| dischargePhase | input | 1 | 1 = discharge phase, 0 = charge phase |
| cvMode | input | 1 | Charger is in constant-voltage mode |
| chargeCurrent | input | IW (12) | Charge current code |
| cellVolt | input | VW (12) | Voltage code of the cell selected by cellSel |
| cellValid | input | 1 | cellVolt holds a fresh reading |
| cellReq | output | 1 | Reading requested |
| cellSel | output | 1 | 0 = cell 1, 1 = cell 2 |
| intervalSecs | input | IVW (16) | Ticks between passes |
| startDelay | input | DW (16) | Settling delay, in cycles minus one |
| endDelay | input | DW (16) | Post-decision delay, in cycles minus one |
| measTimeout | input | TOW (16) | Reading timeout, in cycles minus one |
| chgMinDiff | input | VW (12) | Charge-phase imbalance threshold |
| dchgMinDiff | input | VW (12) | Discharge-phase imbalance threshold |
| midVolt | input | VW (12) | Discharge-phase mid-charge voltage gate |
| minBalCurrent | input | IW (12) | Current floor for balancing in CV mode |
| chargeSuspend | output | 1 | Request to pause the charge path |
| shunt1En | output | 1 | Close bypass of cell 1 (active high) |
| shunt2En | output | 1 | Close bypass of cell 2 (active high) |
| measFault | output | 1 | One-cycle pulse on reading timeout |

## Verification
The external clear and the pass decision both write the shunt register. They can land in the same cycle, when shuntClear is high at the edge where a pass with a clear imbalance loads its choice. The bench provokes this by holding shuntClear across an entire pass whose readings would otherwise close shunt 1. It then requires both enables to be low when chargeSuspend falls and to stay low after the clear is released. A second collision is a tick that arrives just after the decision, while the end delay is running. That tick must neither start a pass nor raise chargeSuspend.

// File: rtl/balancer_pkg.sv
package balancer_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_REQ1,
    ST_REQ2,
    ST_DECIDE,
    ST_ENDWAIT
  } pass_state_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clrShunts;
    logic capCell1;
    logic capCell2;
    logic applyDecision;
  } strobe_t;

endpackage

// File: rtl/balancer_control.sv
module balancer_control
  import balancer_pkg::*;
#(
  parameter int IVW = 16,
  parameter int DW  = 16,
  parameter int TOW = 16
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           secTick,
  input  logic           cellValid,
  input  logic [IVW-1:0] intervalSecs,
  input  logic [DW-1:0]  startDelay,
  input  logic [DW-1:0]  endDelay,
  input  logic [TOW-1:0] measTimeout,
  output strobe_t        strobes,
  output logic           chargeSuspend,
  output logic           cellReq,
  output logic           cellSel,
  output logic           measFault
);

  localparam int CNT_W = (DW > TOW) ? DW : TOW;

  pass_state_t state, nextState;
  logic [CNT_W-1:0] waitCnt;
  logic [IVW-1:0]   tickCnt;
  logic             tickDone;
  logic             timeoutHit;
  logic             startHit;
  logic             endHit;
  logic             toLimit;

  assign tickDone = ({1'b0, tickCnt} + (IVW+1)'(1)) >= {1'b0, intervalSecs};
  assign startHit = (waitCnt == CNT_W'(startDelay));
  assign endHit   = (waitCnt == CNT_W'(endDelay));
  assign toLimit  = (waitCnt == CNT_W'(measTimeout));

  always_comb begin
    nextState  = state;
    strobes    = '0;
    timeoutHit = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (secTick && tickDone) begin
          nextState = ST_SETTLE;
          strobes.clrShunts = 1'b1;
        end
      end
      ST_SETTLE: if (startHit) nextState = ST_REQ1;
      ST_REQ1: begin
        if (cellValid) begin
          strobes.capCell1 = 1'b1;
          nextState = ST_REQ2;
        end else if (toLimit) begin
          timeoutHit = 1'b1;
          nextState = ST_ENDWAIT;
        end
      end
      ST_REQ2: begin
        if (cellValid) begin
          strobes.capCell2 = 1'b1;
          nextState = ST_DECIDE;
        end else if (toLimit) begin
          timeoutHit = 1'b1;
          nextState = ST_ENDWAIT;
        end
      end
      ST_DECIDE: begin
        strobes.applyDecision = 1'b1;
        nextState = ST_ENDWAIT;
      end
      ST_ENDWAIT: if (endHit) nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      waitCnt   <= '0;
      tickCnt   <= '0;
      measFault <= 1'b0;
    end else begin
      state     <= nextState;
      measFault <= timeoutHit;
      if (nextState != state) waitCnt <= '0;
      else                    waitCnt <= waitCnt + CNT_W'(1);
      if (state != ST_IDLE)   tickCnt <= '0;
      else if (secTick)       tickCnt <= tickDone ? '0 : tickCnt + IVW'(1);
    end
  end

  assign chargeSuspend = (state == ST_SETTLE) || (state == ST_REQ1) ||
                         (state == ST_REQ2)   || (state == ST_DECIDE);
  assign cellReq = (state == ST_REQ1) || (state == ST_REQ2);
  assign cellSel = (state == ST_REQ2);

endmodule

// File: rtl/balancer_datapath.sv
module balancer_datapath
  import balancer_pkg::*;
#(
  parameter int VW = 12,
  parameter int IW = 12
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       strobes,
  input  logic          shuntClear,
  input  logic          dischargePhase,
  input  logic          cvMode,
  input  logic [IW-1:0] chargeCurrent,
  input  logic [VW-1:0] cellVolt,
  input  logic [VW-1:0] chgMinDiff,
  input  logic [VW-1:0] dchgMinDiff,
  input  logic [VW-1:0] midVolt,
  input  logic [IW-1:0] minBalCurrent,
  output logic          shunt1En,
  output logic          shunt2En
);

  logic [VW-1:0] v1Q, v2Q;
  logic [VW-1:0] maxV, minV, diffV;
  logic          cell1Higher;
  logic          lowCurrentCv;
  logic          chgWant, dchgWant, balWant;
  logic [1:0]    nextShunts;
  logic [1:0]    shuntQ;

  always_comb begin
    cell1Higher  = v1Q > v2Q;
    maxV         = cell1Higher ? v1Q : v2Q;
    minV         = cell1Higher ? v2Q : v1Q;
    diffV        = maxV - minV;
    lowCurrentCv = cvMode && (chargeCurrent < minBalCurrent);
    chgWant      = (diffV > chgMinDiff) && !lowCurrentCv;
    dchgWant     = (diffV > dchgMinDiff) && (maxV >= midVolt);
    balWant      = dischargePhase ? dchgWant : chgWant;
    nextShunts   = balWant ? (cell1Higher ? 2'b01 : 2'b10) : 2'b00;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      v1Q    <= '0;
      v2Q    <= '0;
      shuntQ <= 2'b00;
    end else begin
      if (strobes.capCell1) v1Q <= cellVolt;
      if (strobes.capCell2) v2Q <= cellVolt;
      if (shuntClear || strobes.clrShunts) shuntQ <= 2'b00;
      else if (strobes.applyDecision)      shuntQ <= nextShunts;
    end
  end

  assign shunt1En = shuntQ[0];
  assign shunt2En = shuntQ[1];

endmodule

// File: rtl/cell_shunt_balancer.sv
module cell_shunt_balancer
  import balancer_pkg::*;
#(
  parameter int VW  = 12,
  parameter int IW  = 12,
  parameter int IVW = 16,
  parameter int DW  = 16,
  parameter int TOW = 16
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           shuntClear,
  input  logic           secTick,
  input  logic           dischargePhase,
  input  logic           cvMode,
  input  logic [IW-1:0]  chargeCurrent,
  input  logic [VW-1:0]  cellVolt,
  input  logic           cellValid,
  output logic           cellReq,
  output logic           cellSel,
  input  logic [IVW-1:0] intervalSecs,
  input  logic [DW-1:0]  startDelay,
  input  logic [DW-1:0]  endDelay,
  input  logic [TOW-1:0] measTimeout,
  input  logic [VW-1:0]  chgMinDiff,
  input  logic [VW-1:0]  dchgMinDiff,
  input  logic [VW-1:0]  midVolt,
  input  logic [IW-1:0]  minBalCurrent,
  output logic           chargeSuspend,
  output logic           shunt1En,
  output logic           shunt2En,
  output logic           measFault
);

  strobe_t strobes;

  balancer_control #(.IVW(IVW), .DW(DW), .TOW(TOW)) ctrl_i (
    .clk(clk), .rstN(rstN), .secTick(secTick), .cellValid(cellValid),
    .intervalSecs(intervalSecs), .startDelay(startDelay),
    .endDelay(endDelay), .measTimeout(measTimeout),
    .strobes(strobes), .chargeSuspend(chargeSuspend),
    .cellReq(cellReq), .cellSel(cellSel), .measFault(measFault)
  );

  balancer_datapath #(.VW(VW), .IW(IW)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .shuntClear(shuntClear),
    .dischargePhase(dischargePhase), .cvMode(cvMode),
    .chargeCurrent(chargeCurrent), .cellVolt(cellVolt),
    .chgMinDiff(chgMinDiff), .dchgMinDiff(dchgMinDiff),
    .midVolt(midVolt), .minBalCurrent(minBalCurrent),
    .shunt1En(shunt1En), .shunt2En(shunt2En)
  );

endmodule

// File: rtl/balancer_checker.sv
module balancer_checker (
  input logic clk,
  input logic rstN,
  input logic shuntClear,
  input logic chargeSuspend,
  input logic cellReq,
  input logic cellValid,
  input logic cellSel,
  input logic shunt1En,
  input logic shunt2En,
  input logic measFault
);

  assert_one_shunt_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({shunt1En, shunt2En}));

  assert_start_open_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(chargeSuspend) |-> (!shunt1En && !shunt2En));

  assert_req_suspended_R3: assert property (@(posedge clk) disable iff (!rstN)
    cellReq |-> chargeSuspend);

  assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (cellReq && !cellValid) |=> (measFault || (cellReq && $stable(cellSel))));

  assert_close_at_release_R8: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(shunt1En) || $rose(shunt2En)) |-> $fell(chargeSuspend));

  assert_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    shuntClear |=> (!shunt1En && !shunt2En));

  assert_fault_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    measFault |=> !measFault);

  assert_fault_state_R10: assert property (@(posedge clk) disable iff (!rstN)
    measFault |-> (!chargeSuspend && !cellReq && !shunt1En && !shunt2En));

endmodule

bind cell_shunt_balancer balancer_checker chk_i (
  .clk(clk), .rstN(rstN), .shuntClear(shuntClear),
  .chargeSuspend(chargeSuspend), .cellReq(cellReq), .cellValid(cellValid),
  .cellSel(cellSel), .shunt1En(shunt1En), .shunt2En(shunt2En),
  .measFault(measFault)
);

// File: tb/cell_shunt_balancer_tb.sv
module cell_shunt_balancer_tb_top;

  localparam int VW = 12, IW = 12, IVW = 16, DW = 16, TOW = 16;
  localparam int START_DLY = 4, END_DLY = 3, TIMEOUT = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic shuntClear = 1'b0, secTick = 1'b0, dischargePhase = 1'b0, cvMode = 1'b0;
  logic [IW-1:0]  chargeCurrent = '0;
  logic [VW-1:0]  cellVolt = '0;
  logic           cellValid = 1'b0;
  logic           cellReq, cellSel;
  logic [IVW-1:0] intervalSecs = 16'd1;
  logic [DW-1:0]  startDelay = DW'(START_DLY);
  logic [DW-1:0]  endDelay = DW'(END_DLY);
  logic [TOW-1:0] measTimeout = TOW'(TIMEOUT);
  logic [VW-1:0]  chgMinDiff = 12'd30, dchgMinDiff = 12'd50, midVolt = 12'd1800;
  logic [IW-1:0]  minBalCurrent = 12'd100;
  logic           chargeSuspend, shunt1En, shunt2En, measFault;

  int checks = 0;
  int errors = 0;

  // pass observations
  int  reqWait, sel0Cycles, firstSel;
  bit  sawSel1, faultAtEnd;
  bit  respOn = 1'b1;
  int  respDelay = 0;

  always #5 clk = ~clk;

  cell_shunt_balancer #(.VW(VW), .IW(IW), .IVW(IVW), .DW(DW), .TOW(TOW)) dut_i (
    .clk(clk), .rstN(rstN), .shuntClear(shuntClear), .secTick(secTick),
    .dischargePhase(dischargePhase), .cvMode(cvMode),
    .chargeCurrent(chargeCurrent), .cellVolt(cellVolt), .cellValid(cellValid),
    .cellReq(cellReq), .cellSel(cellSel), .intervalSecs(intervalSecs),
    .startDelay(startDelay), .endDelay(endDelay), .measTimeout(measTimeout),
    .chgMinDiff(chgMinDiff), .dchgMinDiff(dchgMinDiff), .midVolt(midVolt),
    .minBalCurrent(minBalCurrent), .chargeSuspend(chargeSuspend),
    .shunt1En(shunt1En), .shunt2En(shunt2En), .measFault(measFault)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // model of R5/R6/R7: returns {shunt2,shunt1}
  function automatic int expectShunts(input int v1, input int v2, input bit dis,
                                      input bit cv, input int cur);
    int mx = (v1 > v2) ? v1 : v2;
    int mn = (v1 > v2) ? v2 : v1;
    bit want;
    if (dis) want = ((mx - mn) > int'(dchgMinDiff)) && (mx >= int'(midVolt));
    else     want = ((mx - mn) > int'(chgMinDiff)) && !(cv && (cur < int'(minBalCurrent)));
    if (!want) return 0;
    return (v1 > v2) ? 1 : 2;
  endfunction

  task automatic pulseTick();
    @(negedge clk) secTick = 1'b1;
    @(negedge clk) secTick = 1'b0;
  endtask

  // one full pass; leaves the bench at the negedge where chargeSuspend fell
  task automatic runPass(input int v1, input int v2, output int shuntsOut);
    int holdCnt = 0;
    int guard = 0;
    reqWait = 0; sel0Cycles = 0; firstSel = -1; sawSel1 = 1'b0;
    pulseTick();
    chk("R1 suspend after tick", int'(chargeSuspend), 1);
    chk("R2 shunts open at pass start", int'({shunt2En, shunt1En}), 0);
    while (chargeSuspend && guard < 2000) begin
      guard++;
      if (!cellReq && firstSel < 0) reqWait++;
      if (cellReq && firstSel < 0) firstSel = int'(cellSel);
      if (cellReq && cellSel) sawSel1 = 1'b1;
      if (cellReq && !cellSel) sel0Cycles++;
      if (cellValid) begin
        cellValid = 1'b0;
        holdCnt = 0;
      end else if (cellReq && respOn) begin
        if (holdCnt >= respDelay) begin
          cellValid = 1'b1;
          cellVolt = cellSel ? VW'(v2) : VW'(v1);
        end else holdCnt++;
      end
      @(negedge clk);
    end
    cellValid = 1'b0;
    faultAtEnd = measFault;
    shuntsOut = int'({shunt2En, shunt1En});
  endtask

  task automatic settleIdle();
    repeat (END_DLY + 2) @(negedge clk);
  endtask

  task automatic balanceCase(input string req, input int v1, input int v2,
                             input bit dis, input bit cv, input int cur);
    int sh;
    dischargePhase = dis; cvMode = cv; chargeCurrent = IW'(cur);
    runPass(v1, v2, sh);
    chk(req, sh, expectShunts(v1, v2, dis, cv, cur));
    settleIdle();
  endtask

  task automatic testReset();
    chk("R2 reset suspend", int'(chargeSuspend), 0);
    chk("R7 reset shunts", int'({shunt2En, shunt1En}), 0);
    chk("R3 reset cellReq", int'(cellReq), 0);
    chk("R10 reset fault", int'(measFault), 0);
  endtask

  task automatic testInterval();
    int sh;
    intervalSecs = 16'd3;
    pulseTick();
    chk("R1 first tick no pass", int'(chargeSuspend), 0);
    pulseTick();
    chk("R1 second tick no pass", int'(chargeSuspend), 0);
    runPass(2000, 2000, sh);
    chk("R3 settle cycles before request", reqWait, START_DLY + 1);
    chk("R4 cell 1 requested first", firstSel, 0);
    chk("R4 cell 2 requested", int'(sawSel1), 1);
    chk("R7 equal cells no shunt", sh, 0);
    settleIdle();
    intervalSecs = 16'd1;
  endtask

  task automatic testHoldAndEndDelay();
    int sh;
    dischargePhase = 1'b0; cvMode = 1'b0;
    runPass(2100, 2000, sh);
    chk("R8 shunt1 at release", sh, 1);
    pulseTick();
    chk("R1 tick in end delay ignored", int'(chargeSuspend), 0);
    repeat (20) @(negedge clk);
    chk("R8 shunt1 holds", int'({shunt2En, shunt1En}), 1);
    runPass(2000, 2000, sh);
    chk("R8 next pass reopens", sh, 0);
    settleIdle();
  endtask

  task automatic testHeldRequest();
    int sh;
    respDelay = 5;
    dischargePhase = 1'b0; cvMode = 1'b0;
    runPass(1900, 2000, sh);
    chk("R4 request held until valid", sel0Cycles, 6);
    chk("R7 shunt2 after delayed readings", sh, 2);
    respDelay = 0;
    settleIdle();
  endtask

  task automatic testClearCollision();
    int sh;
    dischargePhase = 1'b0; cvMode = 1'b0;
    shuntClear = 1'b1;
    runPass(2200, 2000, sh);
    chk("R9 clear wins over decision", sh, 0);
    @(negedge clk) shuntClear = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 stays open after clear", int'({shunt2En, shunt1En}), 0);
    settleIdle();
    runPass(2200, 2000, sh);
    chk("R8 close before clear", sh, 1);
    @(negedge clk) shuntClear = 1'b1;
    @(negedge clk) shuntClear = 1'b0;
    chk("R9 clear opens held shunt", int'({shunt2En, shunt1En}), 0);
    settleIdle();
  endtask

  task automatic testTimeout();
    int sh;
    respOn = 1'b0;
    runPass(0, 0, sh);
    chk("R10 request cycles before timeout", sel0Cycles, TIMEOUT + 1);
    chk("R10 fault at release", int'(faultAtEnd), 1);
    chk("R10 shunts open", sh, 0);
    @(negedge clk);
    chk("R10 fault single cycle", int'(measFault), 0);
    respOn = 1'b1;
    settleIdle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testInterval();
    // charge phase, R5 / R7
    balanceCase("R5 R7 charge cell1 high", 2000, 1900, 1'b0, 1'b0, 500);
    balanceCase("R5 R7 charge cell2 high", 1900, 2000, 1'b0, 1'b0, 500);
    balanceCase("R5 diff equal threshold", 2030, 2000, 1'b0, 1'b0, 500);
    balanceCase("R5 diff one over threshold", 2031, 2000, 1'b0, 1'b0, 500);
    balanceCase("R5 CV low current veto", 2100, 2000, 1'b0, 1'b1, 50);
    balanceCase("R5 CV current at floor", 2100, 2000, 1'b0, 1'b1, 100);
    balanceCase("R5 low current outside CV", 2100, 2000, 1'b0, 1'b0, 50);
    // discharge phase, R6
    balanceCase("R6 diff under discharge threshold", 1900, 1860, 1'b1, 1'b0, 0);
    balanceCase("R6 discharge balance", 1860, 1800, 1'b1, 1'b0, 0);
    balanceCase("R6 max below mid", 1700, 1640, 1'b1, 1'b0, 0);
    balanceCase("R6 max equal mid", 1740, 1800, 1'b1, 1'b0, 0);
    balanceCase("R6 CV ignored in discharge", 1860, 1800, 1'b1, 1'b1, 0);
    testHoldAndEndDelay();
    testHeldRequest();
    testClearCollision();
    testTimeout();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule